// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block replaces a distributed one-hot control network with a small interpreter. A 256-word store of 8-bit microinstructions is loaded through a write port, normally while reset is held. After reset the sequencer starts at address 0 and runs one microinstruction after another. Each microinstruction does one of four things: it fires one operation strobe, it makes a conditional jump, it calls a subroutine, or it returns from one.

Operation strobes are arranged as six groups of 32 lines. After a strobe, the sequencer waits for the datapath to report completion on the done input. Two-word branches test one of 30 external condition inputs, in either polarity. Calls save a return address in an internal hardware stack, and returns restore it. If the stack overflows or underflows, the sequencer raises a sticky fault flag and stops until reset.

Top module: `mseq_top`

## Requirements
- R1: A word written through the store write port (write enable, 8-bit address, 8-bit data, taken on a rising clock edge) is the word the sequencer later fetches from that address.
- R2: A word whose bits [7:5] hold a value g from 0 to 5 is a strobe instruction with line number l = bits [4:0]. It drives output bit g*32+l high for exactly one cycle, in the cycle after the edge on which it executes. At most one strobe bit is ever high.
- R3: After a strobe the sequencer stalls, with no further strobes and an unchanged program counter, until done is sampled high. If done is already high, the next instruction executes two edges after the strobe instruction.
- R4: Bits [7:5] = 6 or 7 with a code c from 0 to 29 form a two-word branch on condition input c. Value 6 jumps when the condition is 1, and value 7 jumps when it is 0. A taken branch loads the second word into the program counter. An untaken branch continues two addresses on. Both cases take two cycles.
- R5: Bits [7:5] = 6 or 7 with code 30 is a two-word call. It pushes the address that follows its address word and jumps to the address word. It takes two cycles.
- R6: Bits [7:5] = 6 or 7 with code 31 is a return. It pops the most recent return address into the program counter in one cycle.
- R7: The return stack holds 8 entries. A call made with 8 entries stored, or a return made with none stored, raises fault on the edge where it executes and halts the sequencer.
- R8: Once fault is set, it stays high and no strobe fires until reset.
- R9: The program counter wraps from 255 to 0. This includes the address word of a two-word instruction at address 255.
- R10: An active-low reset clears the program counter, the stack level, the fault flag and all strobe outputs. Execution restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_we | input | 1 | Store write enable |
| cm_waddr | input | 8 | Store write address |
| cm_wdata | input | 8 | Store write data |
| cond_in | input | 30 | Branch condition inputs |
| op_done | input | 1 | Completion of the last strobed operation |
| evoke | output | 192 | One-hot operation strobes, six groups of 32 |
| fault | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Results have fixed latencies. A strobe is visible one edge after its instruction executes. With done held high, strobes, branches and calls each take two cycles and returns take one, so the cycle of every strobe and of the fault can be counted from the first edge after reset release. The bench samples at the falling edge following each rising edge, indexes that sample by its edge number, and compares both the line and the cycle of each strobe, plus the fault cycle, with a reference interpreter written independently in the bench. The stall case moves done low and high at falling edges and expects the next strobe exactly two samples after done is raised.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int IW        = 8;   // microinstruction width
  localparam int OPW       = 3;   // class / group field width
  localparam int CW        = 5;   // line / condition code width
  localparam int NGRP      = 6;   // strobe groups
  localparam int NLINE     = 1 << CW;
  localparam int EVW       = NGRP * NLINE;
  localparam int NCOND     = 30;
  localparam int CODE_CALL = 30;
  localparam int CODE_RET  = 31;

  typedef enum logic [1:0] {ST_EXEC, ST_ADDR, ST_WAIT, ST_HALT} seq_state_e;
  typedef enum logic [1:0] {K_EVOKE, K_BRANCH, K_CALL, K_RET} uop_kind_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [CW-1:0]  code;
  } uword_t;

  function automatic uop_kind_e classify(uword_t w);
    if (int'(w.op) < NGRP)     return K_EVOKE;
    if (int'(w.code) == CODE_CALL) return K_CALL;
    if (int'(w.code) == CODE_RET)  return K_RET;
    return K_BRANCH;
  endfunction

  // even class value jumps on a set condition, odd class value on a clear one
  function automatic logic branch_taken(uword_t w, logic [NCOND-1:0] conds);
    logic c;
    c = 1'b0;
    for (int i = 0; i < NCOND; i++)
      if (int'(w.code) == i) c = conds[i];
    return w.op[0] ? ~c : c;
  endfunction
endpackage

// File: rtl/mseq_cstore.sv
module mseq_cstore #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mseq_rstack.sv
module mseq_rstack #(
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]  slot [DEPTH];
  logic [LW-1:0]  lvl_q;
  logic [IXW-1:0] top_ix;
  logic           do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign top_ix  = IXW'(lvl_q - 1'b1);
  assign top     = empty ? '0 : slot[top_ix];
  assign level   = lvl_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (lvl_q == LW'(i))) slot[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lvl_q <= '0;
    else if (do_push) lvl_q <= lvl_q + 1'b1;
    else if (do_pop)  lvl_q <= lvl_q - 1'b1;
  end
endmodule

// File: rtl/mseq_evoke_dec.sv
module mseq_evoke_dec #(
  parameter int NGRP  = 6,
  parameter int NLINE = 32,
  parameter int GW    = 3,
  parameter int LNW   = 5
) (
  input  logic                  fire,
  input  logic [GW-1:0]         grp,
  input  logic [LNW-1:0]        line,
  output logic [NGRP*NLINE-1:0] lines
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic sel;
    assign sel = fire && (grp == GW'(g));
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      assign lines[g*NLINE + l] = sel && (line == LNW'(l));
    end
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int AW     = 8,
  parameter int SDEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cm_we,
  input  logic [AW-1:0]    cm_waddr,
  input  logic [IW-1:0]    cm_wdata,
  input  logic [NCOND-1:0] cond_in,
  input  logic             op_done,
  output logic [EVW-1:0]   evoke,
  output logic             fault
);
  localparam int LW = $clog2(SDEPTH + 1);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] pc_q, pc_d, pc_inc;
  logic          take_q, take_d, link_q, link_d, fault_d;
  logic [IW-1:0] cm_rdata;
  uword_t        word;
  uop_kind_e     kind;
  logic [EVW-1:0] ev_d;

  // named internal events, used by the bound checker
  logic          evt_fire, evt_push, evt_pop, evt_trap, evt_wait;
  logic          stk_full, stk_empty;
  logic [AW-1:0] stk_top;
  logic [LW-1:0] sp_level;

  mseq_cstore #(.AW(AW), .DW(IW)) u_store (
    .clk(clk), .wr_en(cm_we), .wr_addr(cm_waddr), .wr_data(cm_wdata),
    .rd_addr(pc_q), .rd_data(cm_rdata)
  );

  mseq_rstack #(.AW(AW), .DEPTH(SDEPTH), .LW(LW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(evt_push), .pop(evt_pop), .din(pc_inc),
    .top(stk_top), .level(sp_level), .full(stk_full), .empty(stk_empty)
  );

  mseq_evoke_dec #(.NGRP(NGRP), .NLINE(NLINE), .GW(OPW), .LNW(CW)) u_dec (
    .fire(evt_fire), .grp(word.op), .line(word.code), .lines(ev_d)
  );

  assign word     = uword_t'(cm_rdata);
  assign kind     = classify(word);
  assign pc_inc   = pc_q + 1'b1;
  assign evt_wait = (st_q == ST_WAIT);

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    take_d   = take_q;
    link_d   = link_q;
    fault_d  = fault;
    evt_fire = 1'b0;
    evt_push = 1'b0;
    evt_pop  = 1'b0;
    evt_trap = 1'b0;
    unique case (st_q)
      ST_EXEC: begin
        unique case (kind)
          K_EVOKE: begin
            evt_fire = 1'b1;
            pc_d     = pc_inc;
            st_d     = ST_WAIT;
          end
          K_BRANCH: begin
            take_d = branch_taken(word, cond_in);
            link_d = 1'b0;
            pc_d   = pc_inc;
            st_d   = ST_ADDR;
          end
          K_CALL: begin
            if (stk_full) evt_trap = 1'b1;
            else begin
              take_d = 1'b1;
              link_d = 1'b1;
              pc_d   = pc_inc;
              st_d   = ST_ADDR;
            end
          end
          K_RET: begin
            if (stk_empty) evt_trap = 1'b1;
            else begin
              evt_pop = 1'b1;
              pc_d    = stk_top;
            end
          end
        endcase
      end
      ST_ADDR: begin
        // pc_q points at the address word; the link is the word after it
        evt_push = link_q;
        pc_d     = take_q ? AW'(word) : pc_inc;
        st_d     = ST_EXEC;
      end
      ST_WAIT: begin
        if (op_done) st_d = ST_EXEC;
      end
      default: ;
    endcase
    if (evt_trap) begin
      fault_d = 1'b1;
      st_d    = ST_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_EXEC;
      pc_q   <= '0;
      take_q <= 1'b0;
      link_q <= 1'b0;
      fault  <= 1'b0;
      evoke  <= '0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      take_q <= take_d;
      link_q <= link_d;
      fault  <= fault_d;
      evoke  <= ev_d;
    end
  end
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
  import mseq_pkg::*;
#(
  parameter int AW     = 8,
  parameter int SDEPTH = 8,
  parameter int LW     = $clog2(SDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [EVW-1:0] evoke,
  input logic           fault,
  input logic           op_done,
  input logic           evt_wait,
  input logic           evt_push,
  input logic           evt_pop,
  input logic [AW-1:0]  pc_q,
  input logic [LW-1:0]  sp_level,
  input logic [AW-1:0]  stk_top
);
  p_onehot_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evoke));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evoke) |=> (evoke == '0));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wait && !op_done) |=> ($stable(pc_q) && evoke == '0));

  p_push_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push |=> (sp_level == LW'($past(sp_level) + 1'b1)));

  p_pop_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |=> (pc_q == $past(stk_top)));

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_level <= LW'(SDEPTH)));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (evoke == '0));
endmodule

bind mseq_top mseq_checker #(.AW(AW), .SDEPTH(SDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evoke(evoke), .fault(fault), .op_done(op_done),
  .evt_wait(evt_wait), .evt_push(evt_push), .evt_pop(evt_pop),
  .pc_q(pc_q), .sp_level(sp_level), .stk_top(stk_top)
);

// File: tb/mseq_top_test.sv
module mseq_top_test;
  localparam int LIMIT = 200;
  localparam int MAXE  = 128;

  logic         clk = 1'b0, rst_n = 1'b0, cm_we = 1'b0, op_done = 1'b1;
  logic [7:0]   cm_waddr = '0, cm_wdata = '0;
  logic [29:0]  cond_in = '0;
  logic [191:0] evoke;
  logic         fault;

  int errors = 0, checks = 0;
  logic [7:0] prog [256];
  int exp_t [MAXE], exp_l [MAXE], exp_n, exp_ft;
  int got_t [MAXE], got_l [MAXE], got_n, got_ft;

  mseq_top uut (
    .clk(clk), .rst_n(rst_n), .cm_we(cm_we), .cm_waddr(cm_waddr),
    .cm_wdata(cm_wdata), .cond_in(cond_in), .op_done(op_done),
    .evoke(evoke), .fault(fault)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int a = 0; a < 256; a++) prog[a] = v;
  endtask

  // hold reset, check the cleared state, then write the whole store
  task automatic load_prog();
    rst_n = 1'b0;
    cm_we = 1'b0;
    @(negedge clk);
    check("R10", "fault during reset", int'(fault), 0);
    check("R10", "strobes during reset", int'(|evoke), 0);
    for (int a = 0; a < 256; a++) begin
      cm_we = 1'b1; cm_waddr = 8'(a); cm_wdata = prog[a];
      @(negedge clk);
    end
    cm_we = 1'b0;
  endtask

  // independent interpreter: strobe n at edge t, done assumed high
  function automatic void model();
    logic [7:0] pc, w;
    logic [7:0] stk [8];
    int sp, t;
    pc = '0; sp = 0; t = 0;
    exp_n = 0; exp_ft = -1;
    while (t < LIMIT) begin
      w = prog[pc];
      if (w[7:5] < 3'd6) begin
        if (exp_n < MAXE) begin
          exp_t[exp_n] = t;
          exp_l[exp_n] = 32 * int'(w[7:5]) + int'(w[4:0]);
          exp_n++;
        end
        pc = pc + 8'd1; t += 2;
      end else if (w[4:0] == 5'd31) begin
        if (sp == 0) begin exp_ft = t; break; end
        sp--; pc = stk[sp]; t += 1;
      end else if (w[4:0] == 5'd30) begin
        if (sp == 8) begin exp_ft = t; break; end
        stk[sp] = pc + 8'd2; sp++; pc = prog[pc + 8'd1]; t += 2;
      end else begin
        if (cond_in[w[4:0]] == (w[7:5] == 3'd6)) pc = prog[pc + 8'd1];
        else pc = pc + 8'd2;
        t += 2;
      end
    end
  endfunction

  task automatic run_dut();
    int cnt, idx;
    got_n = 0; got_ft = -1;
    rst_n = 1'b1;
    for (int k = 0; k < LIMIT; k++) begin
      @(negedge clk);
      if (|evoke) begin
        cnt = 0; idx = -1;
        for (int b = 0; b < 192; b++) if (evoke[b]) begin cnt++; idx = b; end
        check("R2", "strobe bits high", cnt, 1);
        if (got_n < MAXE) begin got_t[got_n] = k; got_l[got_n] = idx; got_n++; end
      end
      if (fault && got_ft < 0) got_ft = k;
    end
  endtask

  task automatic compare(input string req);
    check(req, "strobe count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(req, "strobe line", got_l[i], exp_l[i]);
      check(req, "strobe cycle", got_t[i], exp_t[i]);
    end
    check(req, "fault cycle", got_ft, exp_ft);
  endtask

  task automatic run_case(input string req);
    model();
    load_prog();
    run_dut();
    compare(req);
  endtask

  task automatic prog_call_ret();
    fill(8'hFF);
    prog[0] = 8'hDE; prog[1] = 8'h10; prog[2] = 8'h1F;
    prog[16] = 8'h45; prog[17] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_0A7C));

    // R9: wrap from 255 to 0 through a loop of strobes
    fill(8'hFF); cond_in = '0; cond_in[4] = 1'b1;
    prog[0] = 8'hC4; prog[1] = 8'd254; prog[254] = 8'hBF; prog[255] = 8'h47;
    run_case("R9");
    if (got_n > 2) begin
      check("R9", "line after 255", got_l[1], 71);
      check("R9", "cycle of strobe at 255", got_t[1], 4);
      check("R9", "cycle after wrap", got_t[2], 8);
    end
    check("R9", "no fault in loop", got_ft, -1);

    // R4: set-polarity taken, clear-polarity untaken, then underflow
    fill(8'hFF); cond_in = '0; cond_in[5] = 1'b1; cond_in[6] = 1'b1;
    prog[0] = 8'hC5; prog[1] = 8'd8; prog[2] = 8'h02;
    prog[8] = 8'hE6; prog[9] = 8'h40; prog[10] = 8'h21;
    run_case("R4");
    check("R4", "strobe count", got_n, 1);
    if (got_n > 0) begin
      check("R4", "line on taken path", got_l[0], 33);
      check("R4", "cycle on taken path", got_t[0], 4);
    end
    check("R7", "underflow fault cycle", got_ft, 6);

    // R4: clear-polarity branch taken when condition is 0
    cond_in[6] = 1'b0;
    run_case("R4");
    check("R4", "clear-polarity taken, strobes", got_n, 0);
    check("R4", "clear-polarity taken, fault cycle", got_ft, 4);

    // R5, R6: call, strobe, return, strobe, underflow
    prog_call_ret(); cond_in = '0;
    run_case("R5");
    check("R5", "strobe count", got_n, 2);
    if (got_n > 1) begin
      check("R5", "line in subroutine", got_l[0], 69);
      check("R5", "cycle in subroutine", got_t[0], 2);
      check("R6", "line after return", got_l[1], 31);
      check("R6", "cycle after return", got_t[1], 5);
    end
    check("R7", "fault on empty return", got_ft, 7);

    // R7: ninth nested call overflows
    fill(8'hFF); prog[0] = 8'hDE; prog[1] = 8'h00;
    run_case("R7");
    check("R7", "overflow fault cycle", got_ft, 16);
    check("R8", "no strobes after overflow", got_n, 0);

    // R10: stack level cleared by reset, so the call sequence repeats
    prog_call_ret();
    run_case("R10");
    check("R10", "fault after fresh reset", got_ft, 7);

    // R1: rewrite one word during reset, keep the rest
    rst_n = 1'b0;
    @(negedge clk);
    cm_we = 1'b1; cm_waddr = 8'd2; cm_wdata = 8'h3F;
    @(negedge clk);
    cm_we = 1'b0;
    prog[2] = 8'h3F;
    model();
    run_dut();
    compare("R1");
    if (got_n > 1) check("R1", "rewritten word line", got_l[1], 63);

    // R3: stall while done is low
    fill(8'hFF); prog[0] = 8'h41; prog[1] = 8'hA3;
    op_done = 1'b0;
    load_prog();
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "first strobe", int'(evoke[65]), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3", "no strobe while stalled", int'(|evoke), 0);
    end
    op_done = 1'b1;
    @(negedge clk);
    check("R3", "no strobe on release edge", int'(|evoke), 0);
    @(negedge clk);
    check("R3", "second strobe two edges after done", int'(evoke[163]), 1);
    @(negedge clk);
    check("R8", "no fault yet", int'(fault), 0);
    @(negedge clk);
    check("R8", "fault after stall sequence", int'(fault), 1);

    // random programs against the interpreter
    for (int n = 0; n < 40; n++) begin
      for (int a = 0; a < 256; a++) begin
        int r;
        r = int'($urandom % 16);
        if (r < 9)       prog[a] = {3'($urandom % 6), 5'($urandom)};
        else if (r < 12) prog[a] = {2'b11, 1'($urandom), 5'($urandom % 30)};
        else if (r < 14) prog[a] = {2'b11, 1'($urandom), 5'd30};
        else             prog[a] = {2'b11, 1'($urandom), 5'd31};
      end
      cond_in = 30'($urandom);
      run_case("R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule